// File: doc/BRIEF.md
# Clock Frequency Measurement Counter

This block finds the frequency of a main clock whose rate is not known in advance, by comparing it with a slow reference clock of known rate. Once the oscillator-stable input goes high, a measurement window opens on a rising edge of the reference clock. The window closes on the 16th falling edge of the reference after that. While the window is open, the block counts main-clock cycles. When the window closes, the count is frozen and a ready bit is raised. Boot software reads the count and the ready bit from a status register and works out the crystal frequency itself.

The window is built in the reference-clock domain and passed into the main-clock domain through a synchronizer chain. The counter lives in the main-clock domain and saturates rather than wrapping. When the stable input drops (the oscillator is switched off), the result is discarded. The next stable period starts a fresh measurement.

Top module: `clk_freq_meter`

## Requirements
- R1: While rst_n is low at a clock edge, meas_count is reset to zero and meas_ready to 0.
- R2: While osc_stable is low, no window opens and meas_count stays at zero.
- R3: The window opens on the first slow_clk rising edge at which osc_stable is sampled high. It opens only once per stable period.
- R4: The window closes on the 16th slow_clk falling edge after it opened, so it spans 15.5 reference periods at 50% duty. The frozen meas_count equals 31·T_slow/(2·T_main) within ±2 counts.
- R5: meas_ready stays 0 while the window is open, and rises within 4 main_clk cycles after the window closes.
- R6: Once meas_ready is 1, meas_count holds its value for as long as osc_stable stays high.
- R7: meas_count saturates at all-ones (2^CNT_W − 1) rather than wrapping to zero.
- R8: A low level on osc_stable clears meas_count and meas_ready within 4 main_clk cycles. The next high period runs a new, independent measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| main_clk | input | 1 | Clock being measured; the counter runs on it |
| slow_clk | input | 1 | Reference clock of known frequency; defines the window |
| rst_n | input | 1 | Active-low reset, synchronous in both clock domains |
| osc_stable | input | 1 | Oscillator-stable flag, slow_clk domain; high enables a measurement |
| meas_count | output | CNT_W | Main-clock cycles counted over the window, frozen once complete |
| meas_ready | output | 1 | Measurement complete; meas_count is valid |

## Verification
Most internal faults show up directly at the two outputs.

- **Window that never closes:** meas_ready never rises, which is visible about 16 reference periods after osc_stable goes high.
- **Wrong edge count or a misplaced window start:** meas_count falls outside the ±2 band at the moment ready appears.
- **Counter still running after the window:** meas_count moves after ready, on the very next main_clk cycle.
- **Stale state after the oscillator drops:** count or ready is non-zero a few main cycles after osc_stable falls. It also corrupts the next measurement.

// File: rtl/fm_pkg.sv
// Package: default geometry shared by the frequency-meter modules.
// Assumes: every module takes these as parameter defaults and may override them.
package fm_pkg;
    parameter int FM_CNT_W_DEF     = 16;  // width of the result counter
    parameter int FM_WIN_EDGES_DEF = 16;  // reference falling edges per window
    parameter int FM_SYNC_DEF      = 2;   // synchronizer depth into main domain
endpackage

// File: rtl/fm_sync.sv
// Module: fm_sync
// Carries a single-bit level into the clk domain through STAGES flops.
// Assumes: d is a slow level (changes far apart compared with clk), STAGES >= 2.
module fm_sync #(
    parameter int STAGES = fm_pkg::FM_SYNC_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // Capture the asynchronous level in the first flop.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                // Shift the level one stage further along the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/fm_slow_window.sv
// Module: fm_slow_window
// Reference-domain window generator. Opens on the first rising edge with
// stable high and closes on the WIN_EDGES-th falling edge after opening.
// Assumes: stable is synchronous to slow_clk and is not changed at a slow_clk edge.
module fm_slow_window #(
    parameter int WIN_EDGES = fm_pkg::FM_WIN_EDGES_DEF
) (
    input  logic slow_clk,
    input  logic rst_n,
    input  logic stable,
    output logic win_open
);
    localparam int FC_W = $clog2(WIN_EDGES + 1);
    localparam logic [FC_W-1:0] LAST_EDGE = FC_W'(WIN_EDGES - 1);

    logic            started_q;  // set on the opening rising edge
    logic            closed_q;   // set on the closing falling edge
    logic [FC_W-1:0] fall_cnt_q;

    // Open the window on a rising edge once stable is seen high.
    always_ff @(posedge slow_clk) begin
        if (!rst_n || !stable) started_q <= 1'b0;
        else                   started_q <= 1'b1;
    end

    // Count falling edges inside the open window and mark the closing one.
    always_ff @(negedge slow_clk) begin
        if (!rst_n || !stable) begin
            fall_cnt_q <= '0;
            closed_q   <= 1'b0;
        end else if (started_q && !closed_q) begin
            fall_cnt_q <= fall_cnt_q + 1'b1;
            if (fall_cnt_q == LAST_EDGE) closed_q <= 1'b1;
        end
    end

    assign win_open = started_q & ~closed_q;

    // R3
    win_needs_stable_chk: assert property (@(posedge slow_clk) disable iff (!rst_n)
        $rose(started_q) |-> $past(stable));

    // R4
    edge_limit_chk: assert property (@(negedge slow_clk) disable iff (!rst_n)
        fall_cnt_q <= FC_W'(WIN_EDGES));

    // R4
    close_at_last_edge_chk: assert property (@(negedge slow_clk) disable iff (!rst_n)
        $rose(closed_q) |-> (fall_cnt_q == FC_W'(WIN_EDGES)));
endmodule

// File: rtl/fm_main_counter.sv
// Module: fm_main_counter
// Main-domain counter: counts cycles while the synchronized window is open,
// saturates at all-ones, freezes at window close and then raises ready.
// Assumes: win_m and stab_m are already synchronized to clk.
module fm_main_counter #(
    parameter int CNT_W = fm_pkg::FM_CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stab_m,
    input  logic             win_m,
    output logic [CNT_W-1:0] count,
    output logic             ready
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] count_q;
    logic             win_d_q;
    logic             ready_q;

    // Count while open, stop at all-ones, flag completion on the closing edge.
    always_ff @(posedge clk) begin
        if (!rst_n || !stab_m) begin
            count_q <= '0;
            win_d_q <= 1'b0;
            ready_q <= 1'b0;
        end else begin
            win_d_q <= win_m;
            if (win_m && count_q != CNT_MAX) count_q <= count_q + 1'b1;
            if (win_d_q && !win_m)           ready_q <= 1'b1;
        end
    end

    assign count = count_q;
    assign ready = ready_q;

    // R2
    idle_no_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_m && stab_m) |=> $stable(count_q));

    // R5
    ready_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready_q |-> !win_m);

    // R6
    hold_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_q && stab_m) |=> $stable(count_q));

    // R7
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == CNT_MAX && stab_m) |=> (count_q == CNT_MAX));

    // R8
    clear_on_unstable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stab_m |=> (count_q == '0 && !ready_q));
endmodule

// File: rtl/clk_freq_meter.sv
// Module: clk_freq_meter (top)
// Measures main_clk against slow_clk over a window of reference edges and
// presents a frozen count with a ready bit.
// Assumes: rst_n is held low for several cycles of both clocks; osc_stable
// belongs to the slow_clk domain.
module clk_freq_meter #(
    parameter int CNT_W       = fm_pkg::FM_CNT_W_DEF,
    parameter int WIN_EDGES   = fm_pkg::FM_WIN_EDGES_DEF,
    parameter int SYNC_STAGES = fm_pkg::FM_SYNC_DEF
) (
    input  logic             main_clk,
    input  logic             slow_clk,
    input  logic             rst_n,
    input  logic             osc_stable,
    output logic [CNT_W-1:0] meas_count,
    output logic             meas_ready
);
    logic win_slow;
    logic win_main;
    logic stab_main;

    fm_slow_window #(.WIN_EDGES(WIN_EDGES)) u_window (
        .slow_clk (slow_clk),
        .rst_n    (rst_n),
        .stable   (osc_stable),
        .win_open (win_slow)
    );

    fm_sync #(.STAGES(SYNC_STAGES)) u_sync_win (
        .clk   (main_clk),
        .rst_n (rst_n),
        .d     (win_slow),
        .q     (win_main)
    );

    fm_sync #(.STAGES(SYNC_STAGES)) u_sync_stab (
        .clk   (main_clk),
        .rst_n (rst_n),
        .d     (osc_stable),
        .q     (stab_main)
    );

    fm_main_counter #(.CNT_W(CNT_W)) u_counter (
        .clk   (main_clk),
        .rst_n (rst_n),
        .stab_m(stab_main),
        .win_m (win_main),
        .count (meas_count),
        .ready (meas_ready)
    );

    // R1
    reset_idle_chk: assert property (@(posedge main_clk)
        !rst_n |=> (meas_count == '0 && !meas_ready));
endmodule

// File: tb/clk_freq_meter_bench.sv
module clk_freq_meter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NARROW_W   = 8;
    localparam int NARROW_MAX = (1 << NARROW_W) - 1;
    // Each row: {slow half period, expected count = 31*half/(CLK_PERIOD)}
    localparam int NVEC = 4;
    localparam int VEC [NVEC][2] = '{'{50, 155}, '{80, 248}, '{130, 403}, '{200, 620}};

    logic        main_clk = 1'b0;
    logic        slow_clk = 1'b0;
    logic        rst_n    = 1'b0;
    logic        osc_stable = 1'b0;
    logic [15:0] meas_count;
    logic        meas_ready;
    logic [NARROW_W-1:0] n_count;
    logic        n_ready;
    int          half_ns = 50;
    int          n_checks = 0;
    int          n_fail   = 0;

    clk_freq_meter u_clk_freq_meter (
        .main_clk(main_clk), .slow_clk(slow_clk), .rst_n(rst_n),
        .osc_stable(osc_stable), .meas_count(meas_count), .meas_ready(meas_ready)
    );

    clk_freq_meter #(.CNT_W(NARROW_W)) u_narrow (
        .main_clk(main_clk), .slow_clk(slow_clk), .rst_n(rst_n),
        .osc_stable(osc_stable), .meas_count(n_count), .meas_ready(n_ready)
    );

    always #(CLK_PERIOD/2) main_clk = ~main_clk;

    initial begin
        #3;
        forever #(half_ns) slow_clk = ~slow_clk;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit near(input int a, input int e);
        return (a >= e - 2) && (a <= e + 2);
    endfunction

    task automatic drop_stable();
        @(negedge slow_clk); #7;
        osc_stable = 1'b0;
        repeat (4) @(negedge main_clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (60) @(negedge main_clk);
        // R1: reset state
        check(meas_count == 0, "R1 count", meas_count, 0);
        check(meas_ready == 0, "R1 ready", meas_ready, 0);
        rst_n = 1'b1;

        // R2: no counting while stable is low
        repeat (20) @(posedge slow_clk);
        @(negedge main_clk);
        check(meas_count == 0, "R2 count idle", meas_count, 0);
        check(meas_ready == 0, "R2 ready idle", meas_ready, 0);

        for (int v = 0; v < NVEC; v++) begin
            int exp_w;
            int exp_n;
            int held;
            half_ns = VEC[v][0];
            exp_w   = VEC[v][1];
            exp_n   = (exp_w > NARROW_MAX) ? NARROW_MAX : exp_w;
            repeat (3) @(posedge slow_clk);
            @(negedge slow_clk); #7;
            osc_stable = 1'b1;
            // R5: still open after 13 reference periods
            repeat (14) @(posedge slow_clk);
            @(negedge main_clk);
            check(meas_ready == 0, "R5 ready while open", meas_ready, 0);
            for (int i = 0; i < 5000 && !meas_ready; i++) @(negedge main_clk);
            check(meas_ready == 1, "R5 ready after close", meas_ready, 1);
            // R3 R4: window count
            check(near(int'(meas_count), exp_w), "R4 count", meas_count, exp_w);
            check(n_ready == 1, "R5 narrow ready", n_ready, 1);
            if (exp_w > NARROW_MAX + 2)
                check(n_count == NARROW_MAX, "R7 saturate", n_count, NARROW_MAX);
            else
                check(near(int'(n_count), exp_n), "R4 narrow count", n_count, exp_n);
            // R6: held after ready
            held = meas_count;
            repeat (4) @(posedge slow_clk);
            @(negedge main_clk);
            check(meas_count == held, "R6 hold", meas_count, held);
            // R8: clear on stable drop
            drop_stable();
            check(meas_count == 0, "R8 count cleared", meas_count, 0);
            check(meas_ready == 0, "R8 ready cleared", meas_ready, 0);
        end

        // R1: reset in the middle of a measurement
        half_ns = 50;
        repeat (3) @(posedge slow_clk);
        @(negedge slow_clk); #7;
        osc_stable = 1'b1;
        repeat (6) @(posedge slow_clk);
        @(negedge main_clk);
        rst_n = 1'b0;
        repeat (4) @(posedge slow_clk);
        @(negedge main_clk);
        check(meas_count == 0, "R1 mid reset count", meas_count, 0);
        check(meas_ready == 0, "R1 mid reset ready", meas_ready, 0);
        osc_stable = 1'b0;
        rst_n = 1'b1;

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule